// File: doc/BRIEF.md
# Per-Channel Power-Down Supervisor

This block decides, for each of four voice channels, whether the channel is powered up or powered down. It also raises a device-wide global power-down flag. A channel's power state follows its power-down pin, but only once the pin has held a level for a set number of master-clock cycles. The new state is applied on the channel's next frame sync. A channel is also forced down when it stops seeing frame syncs, and the whole device is forced down when the master clock stops, when every channel has lost its syncs, or when all four power-down pins are high.

The power-down pins double as a test-mode selector. When the test-enable pin has settled high, the pins are decoded into digital loopback, analog loopback or DC conversion, either for one channel or for all four. While a valid test code is applied, the pins no longer drive power states, so every pin-driven power transition is frozen. The test controls are gated so that they never reach a channel that is powered down.

The block runs on a system clock. The master clock arrives as a one-cycle `mclk_tick` per master-clock period. A free-running `ref_tick` (nominally 1 µs) times clock absence and the wide-bus sync-loss window. Each channel is driven by a four-state machine: DOWN, WAKE, UP and SLEEP.
- DOWN→WAKE: the pin has settled low.
- WAKE→UP: a frame sync arrives.
- WAKE→DOWN: the pin has settled high again.
- UP→SLEEP: the pin has settled high.
- SLEEP→DOWN: a frame sync arrives.
- SLEEP→UP: the pin has settled low again.
- Any state→DOWN: a forcing loss occurs.

Top module: `chan_power_supervisor`

## Requirements
- R1: A channel that is up goes down only after its power-down pin has been high for PERSIST (16) consecutive master-clock ticks with test mode inactive, and then only at the next frame sync of that channel. Until that sync, `ch_active` stays 1.
- R2: A channel that is down comes up only after its pin has been low for PERSIST ticks and a frame sync has then arrived. A sync that arrives before the pin has settled low leaves it down.
- R3: In 8-bit mode (`mode32`=0), channel i is forced down once MISS_FRAMES×FRAME_LEN master-clock ticks pass with neither `fsx[i]` nor `fsr[i]` pulsing. Syncs on only one of the two directions keep it up, and it recovers once syncs return.
- R4: In 32-bit mode (`mode32`=1), `fsx[0]`/`fsr[0]` serve as the sync for every channel. If they are absent for LOSS32_TICKS reference ticks, every channel is forced down.
- R5: `global_down`=1 and all channels are down when any of these holds: no master-clock tick for CLK_LOSS_TICKS reference ticks; every channel has lost its syncs; or all four settled power-down pins are high outside test mode.
- R6: With test-enable settled high, the pins select a single-channel test as follows, with the channel number given by {pdn[3],pdn[2]} (pdn[2] is the low bit):
  - pdn[0]=1, pdn[1]=1: digital loopback (`tm_dig_lb`).
  - pdn[0]=0, pdn[1]=1: analog loopback (`tm_ana_lb`).
  - pdn[0]=1, pdn[1]=0: DC conversion (`tm_dc_conv`).
- R7: With test-enable high and pdn[1:0]=00, {pdn[3],pdn[2]} selects an all-channel test: 00 is digital loopback, 01 is analog loopback, 10 is DC conversion. Code 11 is invalid and gives normal operation, with no test output and the pins controlling power.
- R8: Test-enable and the pins must hold for PERSIST ticks before a test code takes effect. While a valid test code is applied, no channel's power state changes through the pins.
- R9: Test outputs are never asserted for a channel that is powered down.
- R10: After reset, all channels are down, `global_down`=1 and all test outputs are 0.
- R11: A power-down pin pulse shorter than PERSIST ticks has no effect on the channel's power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mclk_tick | input | 1 | One pulse per master-clock period |
| ref_tick | input | 1 | Free-running reference tick (1 µs nominal) |
| mode32 | input | 1 | 1 = wide 32-bit bus framing, 0 = per-channel framing |
| pdn | input | NCH | Per-channel power-down pins (test selector when test_en is high) |
| test_en | input | 1 | Test-mode enable |
| fsx | input | NCH | Transmit frame-sync pulses |
| fsr | input | NCH | Receive frame-sync pulses |
| ch_active | output | NCH | 1 = channel powered up |
| global_down | output | 1 | Device-wide power-down |
| tm_dig_lb | output | NCH | Per-channel digital loopback enable |
| tm_ana_lb | output | NCH | Per-channel analog loopback enable |
| tm_dc_conv | output | NCH | Per-channel DC conversion enable |

## Verification
Some properties are checked by the assertions on every cycle:
- A settled pin always takes the raw value it followed.
- A forcing loss always sends the channel to DOWN on the next cycle.
- DOWN never jumps straight to UP.
- State is held while a test code freezes the pins.
- `global_down` never coexists with an active channel.
- A channel receives at most one test control at a time.

Other behaviour needs the bench's scenarios:
- The exact ordering of pin persistence and the following frame sync.
- The length of each loss window.
- That a one-direction sync keeps a channel alive.
- That 32-bit mode shares the channel-0 sync.
- The complete decode table, including the invalid code falling back to pin-driven power control.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;

    typedef enum logic [1:0] {
        CH_DOWN  = 2'd0,
        CH_WAKE  = 2'd1,
        CH_UP    = 2'd2,
        CH_SLEEP = 2'd3
    } ch_state_t;

    typedef enum logic [1:0] {
        TM_NONE = 2'd0,
        TM_DLB  = 2'd1,
        TM_ALB  = 2'd2,
        TM_DCC  = 2'd3
    } tmode_t;

endpackage

// File: rtl/pin_persist.sv
module pin_persist #(
    parameter int   PERSIST = 16,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(PERSIST + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt <= RST_VAL;
            cnt  <= '0;
        end else if (raw == filt) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == CW'(PERSIST - 1)) begin
                filt <= raw;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R1
    filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt != $past(filt)) |-> (filt == $past(raw)));

endmodule

// File: rtl/activity_watch.sv
module activity_watch #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pulse,
    input  logic          ev,
    input  logic [CW-1:0] limit,
    output logic          lost
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            lost <= 1'b1;
        end else if (pulse) begin
            cnt  <= '0;
            lost <= 1'b0;
        end else if (ev && !lost) begin
            if (cnt == limit - CW'(1)) begin
                cnt  <= '0;
                lost <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3
    revive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !lost);

    // R5
    lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && !pulse) |=> lost);

endmodule

// File: rtl/chan_pwr_fsm.sv
module chan_pwr_fsm
    import pwr_sup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync,
    input  logic force_dn,
    input  logic pin_en,
    input  logic pin_dn,
    output logic active
);
    ch_state_t st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CH_DOWN;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (force_dn) begin
            nxt = CH_DOWN;
        end else if (pin_en) begin
            unique case (st)
                CH_DOWN:  if (!pin_dn) nxt = CH_WAKE;
                CH_WAKE:  if (pin_dn) nxt = CH_DOWN; else if (sync) nxt = CH_UP;
                CH_UP:    if (pin_dn) nxt = CH_SLEEP;
                CH_SLEEP: if (!pin_dn) nxt = CH_UP; else if (sync) nxt = CH_DOWN;
                default:  nxt = CH_DOWN;
            endcase
        end
    end

    always_comb begin
        active = (st == CH_UP) || (st == CH_SLEEP);
    end

    // R3
    force_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_dn |=> (st == CH_DOWN));

    // R2
    wake_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_DOWN) |=> (st != CH_UP));

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_en && !force_dn) |=> $stable(st));

endmodule

// File: rtl/chan_power_supervisor.sv
module chan_power_supervisor
    import pwr_sup_pkg::*;
#(
    parameter int NCH            = 4,
    parameter int PERSIST        = 16,
    parameter int FRAME_LEN      = 256,
    parameter int MISS_FRAMES    = 32,
    parameter int CLK_LOSS_TICKS = 12,
    parameter int LOSS32_TICKS   = 512
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mclk_tick,
    input  logic           ref_tick,
    input  logic           mode32,
    input  logic [NCH-1:0] pdn,
    input  logic           test_en,
    input  logic [NCH-1:0] fsx,
    input  logic [NCH-1:0] fsr,
    output logic [NCH-1:0] ch_active,
    output logic           global_down,
    output logic [NCH-1:0] tm_dig_lb,
    output logic [NCH-1:0] tm_ana_lb,
    output logic [NCH-1:0] tm_dc_conv
);
    localparam int CH_W     = $clog2(NCH);
    localparam int FS_LIMIT = MISS_FRAMES * FRAME_LEN;
    localparam int LIM_A    = (FS_LIMIT > LOSS32_TICKS) ? FS_LIMIT : LOSS32_TICKS;
    localparam int LIM_MAX  = (LIM_A > CLK_LOSS_TICKS) ? LIM_A : CLK_LOSS_TICKS;
    localparam int CW       = $clog2(LIM_MAX + 1);

    logic [NCH-1:0] f_pdn;
    logic           f_tst;
    logic [NCH-1:0] sync_ch;
    logic [NCH-1:0] fs_lost;
    logic           clk_lost;
    logic           fs_ev;
    logic [CW-1:0]  fs_limit;
    tmode_t         tm;
    logic           sel_all;
    logic [CH_W-1:0] sel_ch;
    logic           test_active;
    logic           pin_en;
    logic           gd_cond;

    // pin persistence filters
    generate
        for (genvar i = 0; i < NCH; i++) begin : g_pdn
            pin_persist #(.PERSIST(PERSIST), .RST_VAL(1'b1)) u_pp (
                .clk(clk), .rst_n(rst_n), .tick(mclk_tick),
                .raw(pdn[i]), .filt(f_pdn[i])
            );
        end
    endgenerate

    pin_persist #(.PERSIST(PERSIST), .RST_VAL(1'b0)) u_tst (
        .clk(clk), .rst_n(rst_n), .tick(mclk_tick),
        .raw(test_en), .filt(f_tst)
    );

    // master clock presence
    activity_watch #(.CW(CW)) u_clkw (
        .clk(clk), .rst_n(rst_n), .pulse(mclk_tick), .ev(ref_tick),
        .limit(CW'(CLK_LOSS_TICKS)), .lost(clk_lost)
    );

    // frame-sync activity per channel
    always_comb begin
        fs_ev    = mode32 ? ref_tick : mclk_tick;
        fs_limit = mode32 ? CW'(LOSS32_TICKS) : CW'(FS_LIMIT);
    end

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_fs
            assign sync_ch[i] = mode32 ? (fsx[0] | fsr[0]) : (fsx[i] | fsr[i]);
            activity_watch #(.CW(CW)) u_fsw (
                .clk(clk), .rst_n(rst_n), .pulse(sync_ch[i]), .ev(fs_ev),
                .limit(fs_limit), .lost(fs_lost[i])
            );
        end
    endgenerate

    // test-code decode
    always_comb begin
        tm      = TM_NONE;
        sel_all = 1'b0;
        sel_ch  = f_pdn[2 +: CH_W];
        if (f_tst) begin
            unique case (f_pdn[1:0])
                2'b11: tm = TM_DLB;
                2'b10: tm = TM_ALB;
                2'b01: tm = TM_DCC;
                2'b00: begin
                    sel_all = 1'b1;
                    unique case (f_pdn[3:2])
                        2'b00:   tm = TM_DLB;
                        2'b01:   tm = TM_ALB;
                        2'b10:   tm = TM_DCC;
                        default: tm = TM_NONE;
                    endcase
                end
                default: tm = TM_NONE;
            endcase
        end
    end

    always_comb begin
        test_active = (tm != TM_NONE);
        pin_en      = !test_active;
        gd_cond     = clk_lost | (&fs_lost) | (pin_en & (&f_pdn));
    end

    // per-channel power state machines
    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            chan_pwr_fsm u_fsm (
                .clk(clk), .rst_n(rst_n), .sync(sync_ch[i]),
                .force_dn(fs_lost[i] | gd_cond), .pin_en(pin_en),
                .pin_dn(f_pdn[i]), .active(ch_active[i])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) global_down <= 1'b1;
        else        global_down <= gd_cond;
    end

    // test controls
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            logic hit;
            hit = ch_active[i] & (sel_all | (sel_ch == CH_W'(i)));
            tm_dig_lb[i]  = hit & (tm == TM_DLB);
            tm_ana_lb[i]  = hit & (tm == TM_ALB);
            tm_dc_conv[i] = hit & (tm == TM_DCC);
        end
    end

    // R5
    gdown_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        global_down |-> (ch_active == '0));

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_tmchk
            // R6
            tm_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0({tm_dig_lb[i], tm_ana_lb[i], tm_dc_conv[i]}));
        end
    endgenerate

endmodule

// File: tb/sim_chan_power_supervisor.sv
module sim_chan_power_supervisor;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic           mclk_en = 1'b1;
    logic           mode32  = 1'b0;
    logic [NCH-1:0] pdn     = '0;
    logic           test_en = 1'b0;
    logic [NCH-1:0] en_x    = '1;
    logic [NCH-1:0] en_r    = '1;
    logic [NCH-1:0] man_x   = '0;
    logic [NCH-1:0] auto_x;
    logic [NCH-1:0] auto_r;
    logic           ref_tick;

    wire            mclk_tick = mclk_en;
    wire [NCH-1:0]  fsx = auto_x | man_x;
    wire [NCH-1:0]  fsr = auto_r;

    wire [NCH-1:0]  ch_active, tm_dig_lb, tm_ana_lb, tm_dc_conv;
    wire            global_down;

    chan_power_supervisor #(
        .NCH(NCH), .PERSIST(16), .FRAME_LEN(8), .MISS_FRAMES(4),
        .CLK_LOSS_TICKS(12), .LOSS32_TICKS(20)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .mclk_tick(mclk_tick), .ref_tick(ref_tick),
        .mode32(mode32), .pdn(pdn), .test_en(test_en), .fsx(fsx), .fsr(fsr),
        .ch_active(ch_active), .global_down(global_down),
        .tm_dig_lb(tm_dig_lb), .tm_ana_lb(tm_ana_lb), .tm_dc_conv(tm_dc_conv)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // background frame and reference ticks
    initial begin
        int ph;
        ph = 0;
        auto_x = '0; auto_r = '0; ref_tick = 1'b0;
        forever begin
            @(negedge clk);
            ph = ph + 1;
            auto_x   = en_x & {NCH{(ph % 8) == 0}};
            auto_r   = en_r & {NCH{(ph % 8) == 4}};
            ref_tick = ((ph % 4) == 0);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse1(int i);
        man_x[i] = 1'b1;
        @(negedge clk);
        man_x[i] = 1'b0;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // {pdn, dig_lb, ana_lb, dc_conv} with test_en held high
    localparam logic [15:0] VEC [6] = '{
        {4'b1011, 4'b0100, 4'b0000, 4'b0000},
        {4'b1110, 4'b0000, 4'b1000, 4'b0000},
        {4'b0101, 4'b0000, 4'b0000, 4'b0010},
        {4'b0000, 4'b1111, 4'b0000, 4'b0000},
        {4'b0100, 4'b0000, 4'b1111, 4'b0000},
        {4'b1000, 4'b0000, 4'b0000, 4'b1111}
    };

    initial begin
        cyc(3);
        chk("R10 active", ch_active, 4'h0);
        chk("R10 gdown", global_down, 1'b1);
        chk("R10 tm", {tm_dig_lb, tm_ana_lb, tm_dc_conv}, 12'h0);
        rst_n = 1'b1;
        cyc(50);
        chk("R2 startup active", ch_active, 4'hF);
        chk("R5 startup gdown", global_down, 1'b0);

        // R11, R1, R2 on channel 1 with manual syncs
        en_x[1] = 1'b0; en_r[1] = 1'b0;
        pulse1(1);
        pdn[1] = 1'b1; cyc(12); pdn[1] = 1'b0;
        pulse1(1); cyc(2);
        chk("R11 short pulse", ch_active[1], 1'b1);
        pulse1(1);
        pdn[1] = 1'b1; cyc(20);
        chk("R1 waits for sync", ch_active[1], 1'b1);
        pulse1(1); cyc(2);
        chk("R1 down at sync", ch_active[1], 1'b0);
        pdn[1] = 1'b0; cyc(10);
        pulse1(1); cyc(2);
        chk("R2 early sync ignored", ch_active[1], 1'b0);
        cyc(8);
        chk("R2 waits for sync", ch_active[1], 1'b0);
        pulse1(1); cyc(2);
        chk("R2 up at sync", ch_active[1], 1'b1);
        en_x[1] = 1'b1; en_r[1] = 1'b1;
        cyc(10);

        // R3 sync loss on channel 2
        en_x[2] = 1'b0; cyc(80);
        chk("R3 one direction keeps up", ch_active, 4'hF);
        en_r[2] = 1'b0; cyc(50);
        chk("R3 both lost", ch_active, 4'b1011);
        en_x[2] = 1'b1; en_r[2] = 1'b1; cyc(40);
        chk("R3 recover", ch_active, 4'hF);

        // R8 test inputs need persistence
        test_en = 1'b1; pdn = VEC[0][15:12];
        cyc(12);
        chk("R8 not yet applied", {tm_dig_lb, tm_ana_lb, tm_dc_conv}, 12'h0);
        // R6, R7, R8 decode table
        for (int k = 0; k < 6; k++) begin
            pdn = VEC[k][15:12];
            cyc(20);
            chk("R6/R7 dig_lb", tm_dig_lb, VEC[k][11:8]);
            chk("R6/R7 ana_lb", tm_ana_lb, VEC[k][7:4]);
            chk("R6/R7 dc_conv", tm_dc_conv, VEC[k][3:0]);
            chk("R8 frozen power", ch_active, 4'hF);
        end
        test_en = 1'b0; pdn = '0; cyc(20);
        chk("R8 exit", {ch_active, tm_dig_lb, tm_ana_lb, tm_dc_conv}, 16'hF000);

        // R7 invalid code acts as normal operation
        test_en = 1'b1; pdn = 4'b1100; cyc(30);
        chk("R7 invalid no test", {tm_dig_lb, tm_ana_lb, tm_dc_conv}, 12'h0);
        chk("R7 invalid pins control", ch_active, 4'b0011);
        test_en = 1'b0; pdn = '0; cyc(40);
        chk("R7 restore", ch_active, 4'hF);

        // R9 test never reaches a down channel
        en_x[1] = 1'b0; en_r[1] = 1'b0; cyc(50);
        chk("R9 ch1 down", ch_active, 4'b1101);
        test_en = 1'b1; pdn = 4'b0000; cyc(20);
        chk("R9 all dig_lb", tm_dig_lb, 4'b1101);
        pdn = 4'b0101; cyc(20);
        chk("R9 dc on down ch", tm_dc_conv, 4'b0000);
        test_en = 1'b0; pdn = '0;
        en_x[1] = 1'b1; en_r[1] = 1'b1; cyc(50);
        chk("R9 restore", ch_active, 4'hF);

        // R5 all pins high
        pdn = 4'hF; cyc(25);
        chk("R5 all pins gdown", {global_down, ch_active}, 5'b10000);
        pdn = '0; cyc(50);
        chk("R5 pins recover", {global_down, ch_active}, 5'b01111);

        // R5 all syncs missing
        en_x = '0; en_r = '0; cyc(50);
        chk("R5 all syncs gdown", {global_down, ch_active}, 5'b10000);
        en_x = '1; en_r = '1; cyc(60);
        chk("R5 syncs recover", {global_down, ch_active}, 5'b01111);

        // R5 master clock absence
        mclk_en = 1'b0; cyc(30);
        chk("R5 clock short gap", global_down, 1'b0);
        cyc(30);
        chk("R5 clock lost", {global_down, ch_active}, 5'b10000);
        mclk_en = 1'b1; cyc(60);
        chk("R5 clock recover", {global_down, ch_active}, 5'b01111);

        // R4 32-bit mode
        mode32 = 1'b1; en_x = 4'b0001; en_r = 4'b0001; cyc(60);
        chk("R4 shared sync", ch_active, 4'hF);
        en_x = '0; en_r = '0; cyc(40);
        chk("R4 within window", ch_active, 4'hF);
        cyc(60);
        chk("R4 window expired", {global_down, ch_active}, 5'b10000);
        mode32 = 1'b0; en_x = '1; en_r = '1; cyc(60);
        chk("R4 recover", ch_active, 4'hF);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule